// File: doc/BRIEF.md
# 10GBASE-R High Bit-Error-Rate Monitor

This block watches the 2-bit sync header of each received 66-bit block on a 10GBASE-R link. While block alignment is reported, it counts headers that are neither 01 nor 10 over back-to-back fixed windows. The window length is a parameter in clock cycles, nominally 125 µs at the PCS clock rate. If 16 bad headers fall inside one window, the link is flagged as running above a 10^-4 bit error rate. The flag stays raised until a full window passes without reaching that count.

A second, independent counter tallies blocks that the downstream decoder reports as errored. Both counters saturate instead of wrapping, and each has its own synchronous clear input. Both counters and the flag are visible on output ports. Locating block boundaries and decoding 64b/66b are left to neighbouring blocks.

Top module: `ber_hi_monitor`

## Requirements
- R1: While `block_lock` is low, `ber_count` reads 0 on the following cycle, `hi_ber` is 0, and the window timer is held at its start. The first locked cycle is therefore cycle 0 of a fresh window.
- R2: A header is bad when `hdr_valid`=1, `block_lock`=1 and `sync_hdr` is 2'b00 or 2'b11. Each bad header raises `ber_count` by one on the next cycle. The values 2'b01 and 2'b10, and any header without `hdr_valid`, leave the count unchanged.
- R3: When a bad header takes the count of the current window to THRESH (16), `hi_ber` is 1 on the next cycle.
- R4: Windows are WIN_CYCLES locked cycles long. On the last cycle of each window, `ber_count` returns to 0 on the next cycle. A bad header in that last cycle still counts toward that window's decision.
- R5: `hi_ber` stays 1 until the end of a window in which the count never reached THRESH, and drops on the next cycle.
- R6: `ber_clr` zeroes `ber_count` on the next cycle and wins over a bad header in the same cycle. It leaves `hi_ber` unchanged.
- R7: `ber_count` saturates at 2^BER_W-1 (63) and does not wrap.
- R8: Each cycle with `blk_err`=1 raises `eblk_count` by one on the next cycle, whatever the lock state. `eblk_clr` zeroes it and wins over a simultaneous `blk_err`.
- R9: `eblk_count` saturates at 2^EBLK_W-1.
- R10: After reset, `hi_ber`, `ber_count` and `eblk_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCS receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| block_lock | input | 1 | Block alignment achieved |
| hdr_valid | input | 1 | `sync_hdr` carries a new header this cycle |
| sync_hdr | input | 2 | Sync header of the received block |
| blk_err | input | 1 | Received block decoded as errored |
| ber_clr | input | 1 | Clear the bad-header count |
| eblk_clr | input | 1 | Clear the errored-block count |
| hi_ber | output | 1 | High bit error rate flag |
| ber_count | output | BER_W | Bad headers counted in the current window |
| eblk_count | output | EBLK_W | Saturating errored-block count |

## Verification
Two events can land on the same cycle. The first pair is a bad header with `ber_clr`. The second pair is a bad header with the final cycle of a window. The bench forces both collisions on purpose. It drives a clear together with the 16th bad header, and it aligns a burst so that its last bad header falls on the window's closing cycle. Each cycle a queued expectation, derived from R2 to R6, is compared with the outputs. It shows that the clear suppresses the flag while the window-closing header still raises it, even though the count restarts.

// File: rtl/ber_hi_monitor.sv
module ber_hi_monitor #(
  parameter int WIN_CYCLES = 19531,
  parameter int THRESH     = 16,
  parameter int BER_W      = 6,
  parameter int EBLK_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block_lock,
  input  logic              hdr_valid,
  input  logic [1:0]        sync_hdr,
  input  logic              blk_err,
  input  logic              ber_clr,
  input  logic              eblk_clr,
  output logic              hi_ber,
  output logic [BER_W-1:0]  ber_count,
  output logic [EBLK_W-1:0] eblk_count
);
  localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0]     WIN_LAST = TW'(WIN_CYCLES - 1);
  localparam logic [BER_W-1:0]  BER_MAX  = {BER_W{1'b1}};
  localparam logic [BER_W-1:0]  BER_PRE  = BER_W'(THRESH - 1);
  localparam logic [EBLK_W-1:0] EBLK_MAX = {EBLK_W{1'b1}};

  logic [TW-1:0]     win_q;
  logic [BER_W-1:0]  ber_q;
  logic [EBLK_W-1:0] eblk_q;
  logic              hit_q, hi_q;

  wire bad_hdr = block_lock & hdr_valid & (sync_hdr[1] ~^ sync_hdr[0]);
  wire win_end = block_lock & (win_q == WIN_LAST);
  wire reach   = bad_hdr & ~ber_clr & (ber_q >= BER_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      ber_q  <= '0;
      hit_q  <= 1'b0;
      hi_q   <= 1'b0;
      eblk_q <= '0;
    end else begin
      win_q <= (!block_lock || win_end) ? '0 : win_q + 1'b1;

      if (!block_lock || ber_clr || win_end)
        ber_q <= '0;
      else if (bad_hdr && ber_q != BER_MAX)
        ber_q <= ber_q + 1'b1;

      if (!block_lock || win_end)
        hit_q <= 1'b0;
      else if (reach)
        hit_q <= 1'b1;

      if (!block_lock)
        hi_q <= 1'b0;
      else if (reach)
        hi_q <= 1'b1;
      else if (win_end)
        hi_q <= hit_q;

      if (eblk_clr)
        eblk_q <= '0;
      else if (blk_err && eblk_q != EBLK_MAX)
        eblk_q <= eblk_q + 1'b1;
    end
  end

  assign hi_ber     = hi_q;
  assign ber_count  = ber_q;
  assign eblk_count = eblk_q;
endmodule

// File: rtl/ber_hi_monitor_chk.sv
module ber_hi_monitor_chk #(
  parameter int BER_W  = 6,
  parameter int EBLK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              block_lock,
  input logic              hdr_valid,
  input logic [1:0]        sync_hdr,
  input logic              blk_err,
  input logic              ber_clr,
  input logic              eblk_clr,
  input logic              hi_ber,
  input logic [BER_W-1:0]  ber_count,
  input logic [EBLK_W-1:0] eblk_count
);
  AST_UNLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !block_lock |=> (ber_count == '0 && !hi_ber)); // R1
  AST_BER_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ber_count != $past(ber_count)) |-> (ber_count == '0 || (ber_count == $past(ber_count) + BER_W'(1) && $past(block_lock && hdr_valid && sync_hdr[1] == sync_hdr[0])))); // R2
  AST_HIBER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_ber) |-> $past(block_lock && hdr_valid && sync_hdr[1] == sync_hdr[0] && !ber_clr)); // R3
  AST_BER_CLR: assert property (@(posedge clk) disable iff (!rst_n) ber_clr |=> ber_count == '0); // R6
  AST_EBLK_CLR: assert property (@(posedge clk) disable iff (!rst_n) eblk_clr |=> eblk_count == '0); // R8
  AST_EBLK_STEP: assert property (@(posedge clk) disable iff (!rst_n) (eblk_count != $past(eblk_count)) |-> (eblk_count == '0 || $past(blk_err))); // R8
  AST_EBLK_SAT: assert property (@(posedge clk) disable iff (!rst_n) (eblk_count == {EBLK_W{1'b1}} && !eblk_clr) |=> eblk_count == {EBLK_W{1'b1}}); // R9
endmodule

bind ber_hi_monitor ber_hi_monitor_chk #(.BER_W(BER_W), .EBLK_W(EBLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .block_lock(block_lock), .hdr_valid(hdr_valid),
  .sync_hdr(sync_hdr), .blk_err(blk_err), .ber_clr(ber_clr), .eblk_clr(eblk_clr),
  .hi_ber(hi_ber), .ber_count(ber_count), .eblk_count(eblk_count));

// File: tb/sim_ber_hi_monitor.sv
`timescale 1ns/1ps
module sim_ber_hi_monitor;
  localparam int WIN = 100, TH = 16, BW = 6, EW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic block_lock = 1'b0, hdr_valid = 1'b0, blk_err = 1'b0, ber_clr = 1'b0, eblk_clr = 1'b0;
  logic [1:0] sync_hdr = 2'b01;
  logic hi_ber;
  logic [BW-1:0] ber_count;
  logic [EW-1:0] eblk_count;

  int checks = 0, errors = 0;
  int m_win = 0, m_ber = 0, m_eblk = 0;
  bit m_hit = 0, m_hi = 0;
  int  qb[$], qe[$];
  bit  qh[$];
  string qt[$];

  always #2 clk = ~clk;

  ber_hi_monitor #(.WIN_CYCLES(WIN), .THRESH(TH), .BER_W(BW), .EBLK_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .block_lock(block_lock), .hdr_valid(hdr_valid),
    .sync_hdr(sync_hdr), .blk_err(blk_err), .ber_clr(ber_clr), .eblk_clr(eblk_clr),
    .hi_ber(hi_ber), .ber_count(ber_count), .eblk_count(eblk_count));

  task automatic chk(input string tag, input int ab, input bit ah, input int ae,
                     input int eb, input bit eh, input int ee);
    checks++;
    if (ab != eb || ah != eh || ae != ee) begin
      errors++;
      $display("FAIL %s: ber=%0d hi=%0d eblk=%0d, expected ber=%0d hi=%0d eblk=%0d",
               tag, ab, ah, ae, eb, eh, ee);
    end
  endtask

  task automatic step(input bit lk, input bit hv, input bit [1:0] hd, input bit be,
                      input bit bc, input bit ec, input string tag);
    bit bad, wend, reach;
    @(negedge clk);
    block_lock = lk; hdr_valid = hv; sync_hdr = hd; blk_err = be; ber_clr = bc; eblk_clr = ec;
    bad   = lk && hv && (hd == 2'b00 || hd == 2'b11);
    wend  = lk && (m_win == WIN - 1);
    reach = bad && !bc && (m_ber >= TH - 1);
    if (!lk) m_hi = 0; else if (reach) m_hi = 1; else if (wend) m_hi = m_hit;
    if (!lk || wend) m_hit = 0; else if (reach) m_hit = 1;
    if (!lk || bc || wend) m_ber = 0; else if (bad && m_ber < (1 << BW) - 1) m_ber++;
    m_win = (!lk || wend) ? 0 : m_win + 1;
    if (ec) m_eblk = 0; else if (be && m_eblk < (1 << EW) - 1) m_eblk++;
    qb.push_back(m_ber); qh.push_back(m_hi); qe.push_back(m_eblk); qt.push_back(tag);
  endtask

  task automatic run(input int n, input bit lk, input bit hv, input bit [1:0] hd,
                     input bit be, input string tag);
    for (int i = 0; i < n; i++) step(lk, hv, hd, be, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (qb.size() > 0)
      chk(qt.pop_front(), int'(ber_count), hi_ber, int'(eblk_count),
          qb.pop_front(), qh.pop_front(), qe.pop_front());
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset", int'(ber_count), hi_ber, int'(eblk_count), 0, 0, 0);

    run(5, 0, 1, 2'b00, 0, "R1 unlocked bad headers");
    run(3, 1, 1, 2'b01, 0, "R2 valid 01");
    run(3, 1, 1, 2'b10, 0, "R2 valid 10");
    run(3, 1, 0, 2'b11, 0, "R2 no strobe");
    run(4, 1, 1, 2'b00, 0, "R2 bad 00");
    run(4, 1, 1, 2'b11, 0, "R2 bad 11");
    run(3, 0, 0, 2'b01, 0, "R1 lock drop");

    run(15, 1, 1, 2'b11, 0, "R2 burst");
    step(1, 1, 2'b00, 0, 1, 0, "R6 clear beats 16th header");
    run(16, 1, 1, 2'b00, 0, "R3 reach threshold");
    run(20, 1, 1, 2'b01, 0, "R5 hold in window");
    run(WIN, 1, 1, 2'b10, 0, "R4 window rollover");
    step(1, 1, 2'b10, 0, 1, 0, "R6 clear keeps flag");
    run(WIN, 1, 1, 2'b10, 0, "R5 clean window drops flag");

    run(1, 0, 0, 2'b01, 0, "R1 resync");
    run(WIN - 16, 1, 1, 2'b01, 0, "R4 align");
    run(16, 1, 1, 2'b11, 0, "R4 last-cycle header counts");
    run(10, 1, 1, 2'b01, 0, "R5 flag after boundary");

    run(1, 0, 0, 2'b01, 0, "R1 resync");
    run(70, 1, 1, 2'b00, 0, "R7 saturate");
    run(5, 1, 1, 2'b01, 0, "R7 held at max");

    run(5, 0, 0, 2'b01, 1, "R8 errored blocks unlocked");
    step(0, 0, 2'b01, 1, 0, 1, "R8 clear beats error");
    run(20, 1, 0, 2'b01, 1, "R9 saturate errored");
    step(1, 0, 2'b01, 0, 0, 1, "R8 clear");
    run(3, 1, 0, 2'b01, 1, "R8 count again");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule